// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block owns the processor state that trap handling touches: the current mode (privilege level, global interrupt enable, direct/paged translation controls), the saved pre-trap mode, the return address, the exception status (sampled interrupt lines, cause code and subcode), the interrupt enable mask, the bad virtual address, and the load-linked bit together with its keep-once flag. The pipeline presents an exception with its cause, the PC of the faulting instruction and the faulting data address. The block also samples the external interrupt lines every cycle and raises a pending interrupt on its own.

When a trap is taken, the block saves the mode, records the cause and addresses, and one cycle later presents a redirect to the handler. A refill-miss trap (code 0x3F) uses its own entry base. All other causes use the general entry base. When the pipeline signals trap return, the block restores the saved mode and redirects to the saved return address. After a refill handler it also switches translation from direct to paged, and it clears the load-linked bit unless the keep flag asks for it to be kept once.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the privilege level is 0, the interrupt enable is 0, direct translation is on (xlat_da=1), paging is off (xlat_pg=0), the load-linked bit is 0, and no redirect is presented.
- R2: Taking a trap saves the current privilege level and interrupt enable into the saved-mode state, then sets the privilege level to 0 and clears the interrupt enable. These values are visible on the outputs after the trap's clock edge.
- R3: Taking a trap stores exc_pc as the return address, and stores the cause code and subcode; they are visible on cause_code and cause_sub.
- R4: The clock edge that takes a trap raises redirect_vld for exactly one cycle. For cause code 0x3F, redirect_pc is {tlbr_base, 6'b0}; for any other code it is {eentry_base, 6'b0}.
- R5: badv_val is loaded with exc_addr when the trap code is 0x3F, 0x1, 0x2, 0x3, 0x4, 0x7, 0x8 or 0x9. Any other code leaves badv_val unchanged.
- R6: For codes 0x3F, 0x1, 0x2, 0x3, 0x4 and 0x7, vppn_we pulses for one cycle with vppn_val = exc_addr[31:13]. No other code pulses vppn_we.
- R7: A return restores the privilege level and interrupt enable from the saved-mode state, and raises redirect_vld for one cycle with redirect_pc equal to the stored return address.
- R8: A return taken while the stored cause code is 0x3F clears xlat_da and sets xlat_pg. A return with any other stored code leaves both unchanged.
- R9: A return clears the load-linked bit unless the keep flag is set. If the keep flag is set, the return clears the flag and keeps the bit. ll_set sets the bit and klo_set sets the keep flag.
- R10: irq_lines is registered every cycle. An interrupt is pending when the registered lines ANDed with irq_lie are non-zero and the interrupt enable is 1. A pending interrupt is taken as a trap with code 0x0 and subcode 0 at the next clock edge, so the redirect appears two edges after the lines rise.
- R11: An exception presented in the same cycle as a pending interrupt or a return strobe is taken by itself. It records its own code, and the return has no effect.
- R12: prmd_wr loads the saved privilege level and saved interrupt enable from prmd_plv_in and prmd_ie_in when no trap or return is being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_vld | input | 1 | Exception presented this cycle |
| exc_code | input | 6 | Exception cause code |
| exc_sub | input | 9 | Exception cause subcode |
| exc_pc | input | 32 | PC of the trapping or interrupted instruction |
| exc_addr | input | 32 | Faulting virtual address |
| ret_req | input | 1 | Trap-return strobe |
| irq_lines | input | 13 | External interrupt lines |
| irq_lie | input | 13 | Per-line interrupt enable mask |
| eentry_base | input | 26 | General handler base (upper PC bits) |
| tlbr_base | input | 26 | Refill handler base (upper PC bits) |
| prmd_wr | input | 1 | Load the saved-mode state |
| prmd_plv_in | input | 2 | Saved privilege level to load |
| prmd_ie_in | input | 1 | Saved interrupt enable to load |
| ll_set | input | 1 | Set the load-linked bit |
| klo_set | input | 1 | Set the keep-once flag |
| redirect_vld | output | 1 | Redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| cur_plv | output | 2 | Current privilege level |
| cur_ie | output | 1 | Global interrupt enable |
| xlat_da | output | 1 | Direct translation active |
| xlat_pg | output | 1 | Paged translation active |
| ll_bit | output | 1 | Load-linked bit |
| vppn_we | output | 1 | Translation-entry VPPN update strobe |
| vppn_val | output | 19 | VPPN update value |
| badv_val | output | 32 | Bad virtual address |
| cause_code | output | 6 | Stored cause code |
| cause_sub | output | 9 | Stored cause subcode |

## Verification
A corrupted saved-mode field stays hidden until the next return. Then cur_plv or cur_ie carries the wrong value on the edge after ret_req, so the tests chain a trap and a return through user mode. A wrong stored cause code shows up the same way. It appears one edge after the trap on cause_code, but it only affects translation mode when the next return fails to switch xlat_pg. A mis-sampled interrupt line either never redirects or redirects one edge early, and the bench counts those edges exactly.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef logic [5:0] ecode_t;

  localparam ecode_t EC_INT  = 6'h00;
  localparam ecode_t EC_PIL  = 6'h01;
  localparam ecode_t EC_PIS  = 6'h02;
  localparam ecode_t EC_PIF  = 6'h03;
  localparam ecode_t EC_PME  = 6'h04;
  localparam ecode_t EC_PPI  = 6'h07;
  localparam ecode_t EC_ADE  = 6'h08;
  localparam ecode_t EC_ALE  = 6'h09;
  localparam ecode_t EC_TLBR = 6'h3F;

  localparam int SUB_W       = 9;
  localparam int PLV_W       = 2;
  localparam int ENTRY_ALIGN = 6;
  localparam int VPPN_LO     = 13;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TRAP = 2'd1,
    ACT_RET  = 2'd2
  } act_e;

  // page-related causes that also refresh the translation-entry VPPN
  function automatic logic code_loads_vppn(ecode_t c);
    logic r;
    case (c)
      EC_TLBR, EC_PIL, EC_PIS, EC_PIF, EC_PME, EC_PPI: r = 1'b1;
      default:                                         r = 1'b0;
    endcase
    return r;
  endfunction

  // every address-related cause records the bad address
  function automatic logic code_loads_badv(ecode_t c);
    return code_loads_vppn(c) || (c == EC_ADE) || (c == EC_ALE);
  endfunction
endpackage

// File: rtl/trap_irq.sv
module trap_irq #(
  parameter int IRQ_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] irq_lines,
  input  logic [IRQ_W-1:0] irq_lie,
  input  logic             ie,
  output logic             pend
);
  logic [IRQ_W-1:0] is_q;
  logic [IRQ_W-1:0] is_d;

  always_comb begin
    is_d = irq_lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) is_q <= '0;
    else        is_q <= is_d;
  end

  assign pend = ie && (|(is_q & irq_lie));

  // R10
  quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines == '0) |=> !pend);
endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  ecode_t            code,
  input  logic [SUB_W-1:0]  sub,
  input  logic [ADDR_W-1:0] epc,
  input  logic [ADDR_W-1:0] eaddr,
  input  logic              prmd_wr,
  input  logic [PLV_W-1:0]  prmd_plv_in,
  input  logic              prmd_ie_in,
  input  logic              ll_set,
  input  logic              klo_set,
  output logic [PLV_W-1:0]  plv,
  output logic              ie,
  output logic              da,
  output logic              pg,
  output logic              ll,
  output logic [ADDR_W-1:0] era,
  output logic [ADDR_W-1:0] badv,
  output ecode_t            code_q,
  output logic [SUB_W-1:0]  sub_q
);
  logic [PLV_W-1:0]  plv_q, plv_d, pplv_q, pplv_d;
  logic              ie_q, ie_d, pie_q, pie_d;
  logic              da_q, da_d, pg_q, pg_d;
  logic              ll_q, ll_d, klo_q, klo_d;
  logic [ADDR_W-1:0] era_q, era_d, badv_q, badv_d;
  ecode_t            cq, cd;
  logic [SUB_W-1:0]  sq, sd;
  logic              upd_en;

  assign upd_en = (act != ACT_NONE) || prmd_wr || ll_set || klo_set;

  always_comb begin
    plv_d  = plv_q;  ie_d  = ie_q;  pplv_d = pplv_q; pie_d = pie_q;
    da_d   = da_q;   pg_d  = pg_q;  ll_d   = ll_q;   klo_d = klo_q;
    era_d  = era_q;  badv_d = badv_q; cd = cq; sd = sq;
    if (ll_set)  ll_d  = 1'b1;
    if (klo_set) klo_d = 1'b1;
    case (act)
      ACT_TRAP: begin
        pplv_d = plv_q;
        pie_d  = ie_q;
        plv_d  = '0;
        ie_d   = 1'b0;
        era_d  = epc;
        cd     = code;
        sd     = sub;
        if (code_loads_badv(code)) badv_d = eaddr;
      end
      ACT_RET: begin
        plv_d = pplv_q;
        ie_d  = pie_q;
        if (cq == EC_TLBR) begin
          da_d = 1'b0;
          pg_d = 1'b1;
        end
        if (klo_q) klo_d = 1'b0;
        else       ll_d  = 1'b0;
      end
      default: begin
        if (prmd_wr) begin
          pplv_d = prmd_plv_in;
          pie_d  = prmd_ie_in;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plv_q <= '0; ie_q <= 1'b0; pplv_q <= '0; pie_q <= 1'b0;
      da_q  <= 1'b1; pg_q <= 1'b0; ll_q <= 1'b0; klo_q <= 1'b0;
      era_q <= '0; badv_q <= '0; cq <= EC_INT; sq <= '0;
    end else if (upd_en) begin
      plv_q <= plv_d; ie_q <= ie_d; pplv_q <= pplv_d; pie_q <= pie_d;
      da_q  <= da_d;  pg_q <= pg_d; ll_q <= ll_d;     klo_q <= klo_d;
      era_q <= era_d; badv_q <= badv_d; cq <= cd; sq <= sd;
    end
  end

  assign plv = plv_q;  assign ie = ie_q;   assign da = da_q;   assign pg = pg_q;
  assign ll  = ll_q;   assign era = era_q; assign badv = badv_q;
  assign code_q = cq;  assign sub_q = sq;

  // R2
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_TRAP) |=> (plv == '0) && !ie);
  // R7
  restore_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_RET) |=> (plv == $past(pplv_q)) && (ie == $past(pie_q)));
  // R8
  refill_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_RET && cq == EC_TLBR) |=> pg && !da);
  // R9
  ll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_RET && !klo_q) |=> !ll);
endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
  import trap_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int BASE_W = ADDR_W - ENTRY_ALIGN,
  localparam int VPPN_W = ADDR_W - VPPN_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  ecode_t            code,
  input  logic [BASE_W-1:0] eentry_base,
  input  logic [BASE_W-1:0] tlbr_base,
  input  logic [ADDR_W-1:0] era,
  input  logic [VPPN_W-1:0] addr_hi,
  output logic              rd_vld,
  output logic [ADDR_W-1:0] rd_pc,
  output logic              vw,
  output logic [VPPN_W-1:0] vppn
);
  logic              vld_q, vld_d, vw_q, vw_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [VPPN_W-1:0] vppn_q, vppn_d;
  logic [BASE_W-1:0] base_sel;

  always_comb begin
    base_sel = (code == EC_TLBR) ? tlbr_base : eentry_base;
    vld_d    = (act != ACT_NONE);
    pc_d     = pc_q;
    vw_d     = 1'b0;
    vppn_d   = vppn_q;
    if (act == ACT_TRAP) begin
      pc_d = {base_sel, {ENTRY_ALIGN{1'b0}}};
      if (code_loads_vppn(code)) begin
        vw_d   = 1'b1;
        vppn_d = addr_hi;
      end
    end else if (act == ACT_RET) begin
      pc_d = era;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0; vw_q <= 1'b0;
    end else begin
      vld_q <= vld_d; vw_q <= vw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0; vppn_q <= '0;
    end else if (act != ACT_NONE) begin
      pc_q <= pc_d; vppn_q <= vppn_d;
    end
  end

  assign rd_vld = vld_q; assign rd_pc = pc_q; assign vw = vw_q; assign vppn = vppn_q;

  // R4
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_NONE) |=> !rd_vld);
  // R6
  vppn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vw |-> rd_vld);
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IRQ_W  = 13,
  localparam int BASE_W = ADDR_W - ENTRY_ALIGN,
  localparam int VPPN_W = ADDR_W - VPPN_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_vld,
  input  logic [5:0]        exc_code,
  input  logic [SUB_W-1:0]  exc_sub,
  input  logic [ADDR_W-1:0] exc_pc,
  input  logic [ADDR_W-1:0] exc_addr,
  input  logic              ret_req,
  input  logic [IRQ_W-1:0]  irq_lines,
  input  logic [IRQ_W-1:0]  irq_lie,
  input  logic [BASE_W-1:0] eentry_base,
  input  logic [BASE_W-1:0] tlbr_base,
  input  logic              prmd_wr,
  input  logic [PLV_W-1:0]  prmd_plv_in,
  input  logic              prmd_ie_in,
  input  logic              ll_set,
  input  logic              klo_set,
  output logic              redirect_vld,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic [PLV_W-1:0]  cur_plv,
  output logic              cur_ie,
  output logic              xlat_da,
  output logic              xlat_pg,
  output logic              ll_bit,
  output logic              vppn_we,
  output logic [VPPN_W-1:0] vppn_val,
  output logic [ADDR_W-1:0] badv_val,
  output logic [5:0]        cause_code,
  output logic [SUB_W-1:0]  cause_sub
);
  logic              irq_pend;
  logic              take;
  act_e              act;
  ecode_t            sel_code;
  logic [SUB_W-1:0]  sel_sub;
  logic [ADDR_W-1:0] era;

  // exception first, then interrupt, then return
  always_comb begin
    take     = exc_vld || irq_pend;
    sel_code = exc_vld ? exc_code : EC_INT;
    sel_sub  = exc_vld ? exc_sub  : '0;
    if (take)         act = ACT_TRAP;
    else if (ret_req) act = ACT_RET;
    else              act = ACT_NONE;
  end

  trap_irq #(.IRQ_W(IRQ_W)) irq_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .irq_lie(irq_lie),
    .ie(cur_ie), .pend(irq_pend)
  );

  trap_csr #(.ADDR_W(ADDR_W)) csr_i (
    .clk(clk), .rst_n(rst_n), .act(act), .code(sel_code), .sub(sel_sub),
    .epc(exc_pc), .eaddr(exc_addr), .prmd_wr(prmd_wr),
    .prmd_plv_in(prmd_plv_in), .prmd_ie_in(prmd_ie_in),
    .ll_set(ll_set), .klo_set(klo_set),
    .plv(cur_plv), .ie(cur_ie), .da(xlat_da), .pg(xlat_pg), .ll(ll_bit),
    .era(era), .badv(badv_val), .code_q(cause_code), .sub_q(cause_sub)
  );

  trap_redirect #(.ADDR_W(ADDR_W)) rdr_i (
    .clk(clk), .rst_n(rst_n), .act(act), .code(sel_code),
    .eentry_base(eentry_base), .tlbr_base(tlbr_base), .era(era),
    .addr_hi(exc_addr[ADDR_W-1:VPPN_LO]),
    .rd_vld(redirect_vld), .rd_pc(redirect_pc), .vw(vppn_we), .vppn(vppn_val)
  );

  // R11
  exc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |=> (cause_code == $past(exc_code)) && redirect_vld);
  // R3
  era_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |=> (cause_sub == $past(exc_sub)));
endmodule

// File: tb/trap_ctrl_tb_top.sv
module trap_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_vld = 1'b0;
  logic [5:0]  exc_code = '0;
  logic [8:0]  exc_sub = '0;
  logic [31:0] exc_pc = '0, exc_addr = '0;
  logic        ret_req = 1'b0;
  logic [12:0] irq_lines = '0, irq_lie = '0;
  logic [25:0] eentry_base = 26'h0001000, tlbr_base = 26'h0002000;
  logic        prmd_wr = 1'b0;
  logic [1:0]  prmd_plv_in = '0;
  logic        prmd_ie_in = 1'b0, ll_set = 1'b0, klo_set = 1'b0;
  logic        redirect_vld, cur_ie, xlat_da, xlat_pg, ll_bit, vppn_we;
  logic [31:0] redirect_pc, badv_val;
  logic [1:0]  cur_plv;
  logic [18:0] vppn_val;
  logic [5:0]  cause_code;
  logic [8:0]  cause_sub;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  localparam logic [31:0] EENTRY_PC = 32'h0004_0000;
  localparam logic [31:0] TLBR_PC   = 32'h0008_0000;

  always #4 clk = ~clk;

  trap_ctrl dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic raise_exc(logic [5:0] c, logic [8:0] s, logic [31:0] pc, logic [31:0] a);
    @(negedge clk);
    exc_vld = 1'b1; exc_code = c; exc_sub = s; exc_pc = pc; exc_addr = a;
    tick();
    @(negedge clk);
    exc_vld = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret_req = 1'b1;
    tick();
    @(negedge clk); ret_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 plv", 32'(cur_plv), 0);
    chk("R1 ie", 32'(cur_ie), 0);
    chk("R1 da", 32'(xlat_da), 1);
    chk("R1 pg", 32'(xlat_pg), 0);
    chk("R1 ll", 32'(ll_bit), 0);
    chk("R1 redirect", 32'(redirect_vld), 0);
  endtask

  task automatic t_plain_exc();
    @(negedge clk);
    exc_vld = 1'b1; exc_code = 6'h0B; exc_sub = 9'h0; exc_pc = 32'h1C00_0100; exc_addr = 32'hDEAD_0000;
    tick();
    chk("R4 redirect_vld", 32'(redirect_vld), 1);
    chk("R4 general entry", redirect_pc, EENTRY_PC);
    chk("R3 code", 32'(cause_code), 32'h0B);
    chk("R5 badv unchanged", badv_val, 0);
    chk("R6 no vppn", 32'(vppn_we), 0);
    @(negedge clk); exc_vld = 1'b0;
    tick();
    chk("R4 one pulse", 32'(redirect_vld), 0);
    do_ret();
    chk("R7 return to era", redirect_pc, 32'h1C00_0100);
    chk("R8 da kept", 32'(xlat_da), 1);
    chk("R8 pg kept", 32'(xlat_pg), 0);
  endtask

  task automatic t_ade();
    raise_exc(6'h08, 9'h001, 32'h0000_0400, 32'h8000_1234);
    chk("R5 badv ade", badv_val, 32'h8000_1234);
    chk("R3 sub", 32'(cause_sub), 1);
    chk("R6 ade no vppn", 32'(vppn_we), 0);
  endtask

  task automatic t_refill();
    logic [31:0] a = 32'h1234_5678;
    @(negedge clk);
    exc_vld = 1'b1; exc_code = 6'h3F; exc_sub = '0; exc_pc = 32'h0000_0200; exc_addr = a;
    tick();
    chk("R4 refill entry", redirect_pc, TLBR_PC);
    chk("R5 badv refill", badv_val, a);
    chk("R6 vppn_we", 32'(vppn_we), 1);
    chk("R6 vppn_val", 32'(vppn_val), a >> 13);
    @(negedge clk); exc_vld = 1'b0;
    tick();
    chk("R6 vppn pulse", 32'(vppn_we), 0);
    do_ret();
    chk("R7 refill return pc", redirect_pc, 32'h0000_0200);
    chk("R8 da cleared", 32'(xlat_da), 0);
    chk("R8 pg set", 32'(xlat_pg), 1);
  endtask

  task automatic t_user();
    @(negedge clk); prmd_wr = 1'b1; prmd_plv_in = 2'd3; prmd_ie_in = 1'b1;
    tick();
    chk("R12 plv untouched", 32'(cur_plv), 0);
    @(negedge clk); prmd_wr = 1'b0;
    do_ret();
    chk("R12 plv restored", 32'(cur_plv), 3);
    chk("R7 ie restored", 32'(cur_ie), 1);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_lines = 13'h004; irq_lie = 13'h000;
    tick(); tick(); tick();
    chk("R10 masked no redirect", 32'(redirect_vld), 0);
    @(negedge clk); irq_lines = 13'h000; exc_pc = 32'h0000_3000;
    tick();
    @(negedge clk); irq_lie = 13'h004; irq_lines = 13'h004;
    tick();
    chk("R10 not yet", 32'(redirect_vld), 0);
    tick();
    chk("R10 irq redirect", 32'(redirect_vld), 1);
    chk("R10 irq pc", redirect_pc, EENTRY_PC);
    chk("R10 irq code", 32'(cause_code), 0);
    chk("R2 plv0", 32'(cur_plv), 0);
    chk("R2 ie0", 32'(cur_ie), 0);
    chk("R5 badv held", badv_val, 32'h1234_5678);
    @(negedge clk); irq_lines = '0;
    do_ret();
    chk("R2 saved plv", 32'(cur_plv), 3);
    chk("R2 saved ie", 32'(cur_ie), 1);
    chk("R3 irq era", redirect_pc, 32'h0000_3000);
    chk("R8 pg stays", 32'(xlat_pg), 1);
  endtask

  task automatic t_priority();
    @(negedge clk); irq_lie = '0; irq_lines = 13'h004;
    tick();
    @(negedge clk);
    irq_lie = 13'h004; ret_req = 1'b1;
    exc_vld = 1'b1; exc_code = 6'h09; exc_sub = '0; exc_pc = 32'h0000_5000; exc_addr = 32'h0000_0011;
    tick();
    chk("R11 code", 32'(cause_code), 32'h09);
    chk("R11 pc", redirect_pc, EENTRY_PC);
    chk("R11 ret ignored", 32'(cur_plv), 0);
    chk("R5 badv ale", badv_val, 32'h11);
    @(negedge clk); exc_vld = 1'b0; ret_req = 1'b0; irq_lines = '0; irq_lie = '0;
    tick();
  endtask

  task automatic t_ll();
    @(negedge clk); ll_set = 1'b1; klo_set = 1'b1;
    tick();
    chk("R9 ll set", 32'(ll_bit), 1);
    @(negedge clk); ll_set = 1'b0; klo_set = 1'b0;
    do_ret();
    chk("R9 kept once", 32'(ll_bit), 1);
    do_ret();
    chk("R9 cleared", 32'(ll_bit), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tick();
    t_reset();
    t_plain_exc();
    t_ade();
    t_refill();
    t_user();
    t_irq();
    t_priority();
    t_ll();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule